// File: doc/BRIEF.md
# Instruction bundle template decoder

This block takes one 128-bit instruction bundle per cycle. It cuts the bundle into a 5-bit template code and three 41-bit instruction slots. From the template code alone, and without looking at any opcode, it reports three things: which execution-unit class must take each slot, where the explicit stops sit, and whether slots 1 and 2 together hold one extended long instruction. Codes outside the defined set are flagged as illegal, and an illegal bundle releases no slot.

A dispersal stage uses the block to steer slots to the memory, integer, floating-point and branch units. It uses the stop mask to close issue groups. All results are registered, so they appear one clock after the bundle is presented with its valid strobe.

Top module: `bundle_tmpl_dec`

## Requirements
- R1: The template is read from bundle bits [4:0]. Slot 0 is bits [45:5], slot 1 is bits [86:46] and slot 2 is bits [127:87]. Each slot is presented unchanged on its own output port.
- R2: `out_vld` is `in_vld` delayed by exactly one clock edge. All decode results of a bundle appear on the same edge as its `out_vld`.
- R3: The unit classes are coded M=0, I=1, F=2, B=3. Base template index b = code>>1 selects, for slots 0,1,2: b0 M,I,I; b1 M,I,I; b2 M,I,I (long pair); b3 M,M,I; b4 M,M,I; b5 M,F,I; b6 M,M,F; b7 M,I,B; b8 M,B,B; b9 B,B,B; b10 M,M,B; b11 M,F,B.
- R4: Stop mask bit 0 (after slot 0) is set only for codes 8 and 9. Stop mask bit 1 (after slot 1) is set only for codes 2 and 3.
- R5: For a legal code, stop mask bit 2 (end of bundle) equals code bit 0. An even code has no trailing stop and an odd code has one.
- R6: Codes 4 and 5 set `out_long` and report I for both slot 1 and slot 2, with slot-valid mask 3'b011.
- R7: Every other legal code (0 to 23) gives slot-valid mask 3'b111 and `out_long` low.
- R8: Codes 24 to 31 raise `out_illegal` and clear the slot-valid mask, the stop mask, `out_long` and all unit fields.
- R9: While `rst` is high and on the edge after it, `out_vld`, `out_illegal`, `out_long`, the slot-valid mask and the stop mask are all zero.
- R10: In a cycle after `in_vld` was low, `out_vld`, the slot-valid mask, the stop mask, `out_long` and `out_illegal` are zero. The slot data ports keep the last accepted bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Bundle present this cycle |
| in_bundle | input | 128 | Instruction bundle |
| out_vld | output | 1 | Decode results valid |
| out_slot0 | output | 41 | Slot 0 instruction bits |
| out_slot1 | output | 41 | Slot 1 instruction bits |
| out_slot2 | output | 41 | Slot 2 instruction bits |
| out_unit0 | output | 2 | Unit class for slot 0 |
| out_unit1 | output | 2 | Unit class for slot 1 |
| out_unit2 | output | 2 | Unit class for slot 2 |
| out_slot_vld | output | 3 | One bit per slot that carries an instruction to issue |
| out_stop | output | 3 | Stops: after slot 0, after slot 1, end of bundle |
| out_long | output | 1 | Slots 1 and 2 form one extended instruction |
| out_illegal | output | 1 | Template code is reserved |

## Verification
Two results can fall in the same cycle. One is the trailing stop together with the long-pair fusion: code 5 must give `out_long` and stop bit 2 at once. The other is an odd reserved code, whose low bit would imply a trailing stop but which must report an illegal template with an empty stop mask. The bench walks all 32 codes back to back, so each of these pairs lands in one output cycle directly after a differently decoded bundle. Every output field is compared against values derived from the template table in the requirements.

// File: rtl/bundle_tmpl_pkg.sv
package bundle_tmpl_pkg;

  // Slot count is fixed by the bundle format.
  localparam int unsigned SLOTS  = 3;
  // Number of base templates; each has a no-stop and a trailing-stop code.
  localparam int unsigned N_BASE = 12;

  typedef enum logic [1:0] {
    UNIT_M = 2'd0,
    UNIT_I = 2'd1,
    UNIT_F = 2'd2,
    UNIT_B = 2'd3
  } unit_e;

  typedef struct packed {
    unit_e u0;
    unit_e u1;
    unit_e u2;
    logic  stop_a;    // stop after slot 0
    logic  stop_b;    // stop after slot 1
    logic  long_pair; // slots 1 and 2 fused
    logic  known;
  } tmpl_info_t;

  function automatic tmpl_info_t make_info(unit_e a, unit_e b, unit_e c,
                                           logic sa, logic sb, logic lp);
    tmpl_info_t t;
    t.u0 = a;
    t.u1 = b;
    t.u2 = c;
    t.stop_a = sa;
    t.stop_b = sb;
    t.long_pair = lp;
    t.known = 1'b1;
    return t;
  endfunction

  function automatic tmpl_info_t base_lookup(input logic [3:0] idx);
    tmpl_info_t t;
    t = '0;
    case (idx)
      4'd0:  t = make_info(UNIT_M, UNIT_I, UNIT_I, 1'b0, 1'b0, 1'b0);
      4'd1:  t = make_info(UNIT_M, UNIT_I, UNIT_I, 1'b0, 1'b1, 1'b0);
      4'd2:  t = make_info(UNIT_M, UNIT_I, UNIT_I, 1'b0, 1'b0, 1'b1);
      4'd3:  t = make_info(UNIT_M, UNIT_M, UNIT_I, 1'b0, 1'b0, 1'b0);
      4'd4:  t = make_info(UNIT_M, UNIT_M, UNIT_I, 1'b1, 1'b0, 1'b0);
      4'd5:  t = make_info(UNIT_M, UNIT_F, UNIT_I, 1'b0, 1'b0, 1'b0);
      4'd6:  t = make_info(UNIT_M, UNIT_M, UNIT_F, 1'b0, 1'b0, 1'b0);
      4'd7:  t = make_info(UNIT_M, UNIT_I, UNIT_B, 1'b0, 1'b0, 1'b0);
      4'd8:  t = make_info(UNIT_M, UNIT_B, UNIT_B, 1'b0, 1'b0, 1'b0);
      4'd9:  t = make_info(UNIT_B, UNIT_B, UNIT_B, 1'b0, 1'b0, 1'b0);
      4'd10: t = make_info(UNIT_M, UNIT_M, UNIT_B, 1'b0, 1'b0, 1'b0);
      4'd11: t = make_info(UNIT_M, UNIT_F, UNIT_B, 1'b0, 1'b0, 1'b0);
      default: t = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/bundle_split.sv
module bundle_split #(
  parameter int unsigned SLOT_W = 41,
  parameter int unsigned TMPL_W = 5,
  localparam int unsigned NS       = bundle_tmpl_pkg::SLOTS,
  localparam int unsigned BUNDLE_W = TMPL_W + NS * SLOT_W
) (
  input  logic [BUNDLE_W-1:0]        bundle,
  output logic [TMPL_W-1:0]          tmpl,
  output logic [NS-1:0][SLOT_W-1:0]  slots
);

  assign tmpl = bundle[TMPL_W-1:0];

  for (genvar g = 0; g < NS; g++) begin : g_slot
    assign slots[g] = bundle[TMPL_W + g*SLOT_W +: SLOT_W];
  end

endmodule

// File: rtl/tmpl_lookup.sv
module tmpl_lookup #(
  parameter int unsigned TMPL_W = 5,
  localparam int unsigned NS = bundle_tmpl_pkg::SLOTS,
  localparam int unsigned LEGAL_CODES = 2 * bundle_tmpl_pkg::N_BASE
) (
  input  logic [TMPL_W-1:0]   code,
  output logic [NS-1:0][1:0]  units,
  output logic [2:0]          stops,
  output logic                long_pair,
  output logic [NS-1:0]       slot_vld,
  output logic                illegal
);

  bundle_tmpl_pkg::tmpl_info_t info;
  logic legal;

  always_comb begin
    info  = bundle_tmpl_pkg::base_lookup(4'(code >> 1));
    legal = (32'(code) < LEGAL_CODES) && info.known;
    illegal = !legal;
    if (legal) begin
      units[0]  = info.u0;
      units[1]  = info.u1;
      units[2]  = info.u2;
      stops     = {code[0], info.stop_b, info.stop_a};
      long_pair = info.long_pair;
      slot_vld  = info.long_pair ? 3'b011 : 3'b111;
    end else begin
      units     = '0;
      stops     = '0;
      long_pair = 1'b0;
      slot_vld  = '0;
    end
  end

endmodule

// File: rtl/decode_reg.sv
module decode_reg #(
  parameter int unsigned SLOT_W = 41,
  localparam int unsigned NS = bundle_tmpl_pkg::SLOTS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_vld,
  input  logic [NS-1:0][SLOT_W-1:0]  slots_d,
  input  logic [NS-1:0][1:0]         units_d,
  input  logic [2:0]                 stops_d,
  input  logic                       long_d,
  input  logic [NS-1:0]              svld_d,
  input  logic                       illegal_d,
  output logic                       vld_q,
  output logic [NS-1:0][SLOT_W-1:0]  slots_q,
  output logic [NS-1:0][1:0]         units_q,
  output logic [2:0]                 stops_q,
  output logic                       long_q,
  output logic [NS-1:0]              svld_q,
  output logic                       illegal_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= 1'b0;
      slots_q   <= '0;
      units_q   <= '0;
      stops_q   <= '0;
      long_q    <= 1'b0;
      svld_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        slots_q   <= slots_d;
        units_q   <= units_d;
        stops_q   <= stops_d;
        long_q    <= long_d;
        svld_q    <= svld_d;
        illegal_q <= illegal_d;
      end else begin
        stops_q   <= '0;
        long_q    <= 1'b0;
        svld_q    <= '0;
        illegal_q <= 1'b0;
      end
    end
  end

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> vld_q);

  // R10
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!vld_q && svld_q == '0 && stops_q == '0 && !long_q && !illegal_q));

  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(slots_q));

endmodule

// File: rtl/bundle_tmpl_dec.sv
module bundle_tmpl_dec #(
  parameter int unsigned SLOT_W = 41,
  parameter int unsigned TMPL_W = 5,
  localparam int unsigned NS       = bundle_tmpl_pkg::SLOTS,
  localparam int unsigned BUNDLE_W = TMPL_W + NS * SLOT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [BUNDLE_W-1:0]  in_bundle,
  output logic                 out_vld,
  output logic [SLOT_W-1:0]    out_slot0,
  output logic [SLOT_W-1:0]    out_slot1,
  output logic [SLOT_W-1:0]    out_slot2,
  output logic [1:0]           out_unit0,
  output logic [1:0]           out_unit1,
  output logic [1:0]           out_unit2,
  output logic [NS-1:0]        out_slot_vld,
  output logic [2:0]           out_stop,
  output logic                 out_long,
  output logic                 out_illegal
);

  logic [TMPL_W-1:0]          tmpl;
  logic [NS-1:0][SLOT_W-1:0]  slots;
  logic [NS-1:0][1:0]         units;
  logic [2:0]                 stops;
  logic                       long_pair;
  logic [NS-1:0]              svld;
  logic                       illegal;
  logic [NS-1:0][SLOT_W-1:0]  slots_q;
  logic [NS-1:0][1:0]         units_q;

  bundle_split #(.SLOT_W(SLOT_W), .TMPL_W(TMPL_W)) split_i (
    .bundle (in_bundle),
    .tmpl   (tmpl),
    .slots  (slots)
  );

  tmpl_lookup #(.TMPL_W(TMPL_W)) lookup_i (
    .code      (tmpl),
    .units     (units),
    .stops     (stops),
    .long_pair (long_pair),
    .slot_vld  (svld),
    .illegal   (illegal)
  );

  decode_reg #(.SLOT_W(SLOT_W)) reg_i (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .slots_d   (slots),
    .units_d   (units),
    .stops_d   (stops),
    .long_d    (long_pair),
    .svld_d    (svld),
    .illegal_d (illegal),
    .vld_q     (out_vld),
    .slots_q   (slots_q),
    .units_q   (units_q),
    .stops_q   (out_stop),
    .long_q    (out_long),
    .svld_q    (out_slot_vld),
    .illegal_q (out_illegal)
  );

  assign out_slot0 = slots_q[0];
  assign out_slot1 = slots_q[1];
  assign out_slot2 = slots_q[2];
  assign out_unit0 = units_q[0];
  assign out_unit1 = units_q[1];
  assign out_unit2 = units_q[2];

  // R1
  slot0_pass_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_slot0 == $past(in_bundle[TMPL_W + SLOT_W - 1:TMPL_W]));

  // R5
  end_stop_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_stop[2] == ($past(in_bundle[0]) && !out_illegal));

  // R8
  illegal_clears_chk: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_slot_vld == '0 && !out_long && out_stop == '0));

  // R6
  long_pair_chk: assert property (@(posedge clk) disable iff (rst)
    out_long |-> (out_slot_vld == 3'b011 && out_unit1 == 2'd1 && out_unit2 == 2'd1));

  // R4
  single_mid_stop_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $countones(out_stop[1:0]) <= 1);

endmodule

// File: tb/bundle_tmpl_dec_tb_top.sv
`timescale 1ns/1ps
module bundle_tmpl_dec_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [127:0] in_bundle = '0;
  logic         out_vld;
  logic [40:0]  out_slot0, out_slot1, out_slot2;
  logic [1:0]   out_unit0, out_unit1, out_unit2;
  logic [2:0]   out_slot_vld;
  logic [2:0]   out_stop;
  logic         out_long;
  logic         out_illegal;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bundle_tmpl_dec dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_bundle(in_bundle),
    .out_vld(out_vld), .out_slot0(out_slot0), .out_slot1(out_slot1),
    .out_slot2(out_slot2), .out_unit0(out_unit0), .out_unit1(out_unit1),
    .out_unit2(out_unit2), .out_slot_vld(out_slot_vld), .out_stop(out_stop),
    .out_long(out_long), .out_illegal(out_illegal)
  );

  // Per base template: {u0, u1, u2, stop after slot0, stop after slot1, long}
  localparam logic [8:0] BASE_TAB [12] = '{
    {2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0},
    {2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1},
    {2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0},
    {2'd3, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'd2, 2'd3, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [40:0] slot_pat(int code, int g);
    return {3'(g), 8'(code * 7 + g), 30'h1234_5678 ^ 30'(g * 3 + code)};
  endfunction

  function automatic logic [127:0] make_bundle(int code);
    return {slot_pat(code, 2), slot_pat(code, 1), slot_pat(code, 0), 5'(code)};
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(bit v, int code);
    in_vld = v;
    in_bundle = make_bundle(code);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 vld in reset", 128'(out_vld), 0);
    chk("R9 flags in reset", 128'({out_slot_vld, out_stop, out_long, out_illegal}), 0);
    rst = 1'b0;

    // Table walk over all template codes, back to back.
    for (int c = 0; c < 32; c++) begin
      logic [8:0] e;
      bit legal;
      legal = (c < 24);
      e = legal ? BASE_TAB[c >> 1] : 9'd0;
      drive(1'b1, c);
      @(negedge clk);
      chk("R2 out_vld", 128'(out_vld), 1);
      chk("R1 slot0", 128'(out_slot0), 128'(slot_pat(c, 0)));
      chk("R1 slot1", 128'(out_slot1), 128'(slot_pat(c, 1)));
      chk("R1 slot2", 128'(out_slot2), 128'(slot_pat(c, 2)));
      chk(legal ? "R3 units" : "R8 units", 128'({out_unit0, out_unit1, out_unit2}),
          128'(e[8:3]));
      chk(legal ? "R4 interior stops" : "R8 interior stops", 128'(out_stop[1:0]),
          128'({e[1], e[2]}));
      chk(legal ? "R5 end stop" : "R8 end stop", 128'(out_stop[2]),
          128'(legal && (c % 2 == 1)));
      chk(legal ? "R6 long flag" : "R8 long flag", 128'(out_long), 128'(e[0]));
      chk(legal ? (e[0] ? "R6 slot valid" : "R7 slot valid") : "R8 slot valid",
          128'(out_slot_vld), !legal ? 128'(0) : (e[0] ? 128'(3'b011) : 128'(3'b111)));
      chk("R8 illegal flag", 128'(out_illegal), 128'(!legal));
    end

    // R10: idle cycle after a legal bundle clears flags and holds data.
    drive(1'b1, 6);
    @(negedge clk);
    chk("R7 code 6 slot valid", 128'(out_slot_vld), 128'(3'b111));
    drive(1'b0, 17);
    @(negedge clk);
    chk("R10 idle vld", 128'(out_vld), 0);
    chk("R10 idle flags", 128'({out_slot_vld, out_stop, out_long, out_illegal}), 0);
    chk("R10 idle slot0 held", 128'(out_slot0), 128'(slot_pat(6, 0)));
    chk("R10 idle slot2 held", 128'(out_slot2), 128'(slot_pat(6, 2)));

    // R9: reset in the middle of traffic.
    drive(1'b1, 5);
    @(negedge clk);
    chk("R6 code 5 long before reset", 128'(out_long), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 vld after reset", 128'(out_vld), 0);
    chk("R9 flags after reset", 128'({out_slot_vld, out_stop, out_long, out_illegal}), 0);
    rst = 1'b0;
    drive(1'b1, 25);
    @(negedge clk);
    chk("R8 odd reserved code", 128'({out_illegal, out_stop}), 128'(4'b1000));
    drive(1'b0, 0);
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule